// File: doc/BRIEF.md
# Piecewise-Linear Output Gamma Curve

This block applies a programmable output gamma curve to a pixel stream of three 12-bit linear components. The curve sits in a small point RAM. Each stored point keeps, for every color channel, a base value and a delta toward the next point. A separate region table splits the input range into regions at powers of two. For each region the table holds a base offset into the point RAM and the log2 of its segment count. Inputs below the first region follow a straight line from zero. Inputs at or beyond a programmed end point follow an end base value plus an end slope.

Software first fills the region table. It then writes a starting point index and streams six data words per point: red base, green base, blue base, red delta, green delta, blue delta. Each data write moves the load pointer forward by one word. A 3-bit channel write mask decides which channels store the words they receive. The load is complete after the sixth word of the last point. Until then the block passes pixels through unchanged, and it does the same while curve mode is off.

The controller is a three-state machine. ST_IDLE means no complete curve is held. ST_LOAD means a load is in progress. ST_READY means a complete curve is held. An index write (`idx_wr`) moves ST_IDLE, ST_LOAD or ST_READY to ST_LOAD. In ST_LOAD, a restarting index write keeps the machine in ST_LOAD. The final data word moves ST_LOAD to ST_READY. No other input changes the state.

Top module: `rgm_regamma_top`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `out_valid` is 0 and all three outputs are 0. The controller starts in ST_IDLE.
- R2: A pixel presented with `pix_valid` high produces `out_valid` high with its result on the next rising clock edge. A cycle with `pix_valid` low produces `out_valid` low on the next edge.
- R3: When `curve_en` is 0, or no load has completed since reset, each output equals its input component.
- R4: `idx_wr` sets the load pointer to point `idx_pt`, word 0, and enters ST_LOAD. Each `data_wr` in ST_LOAD advances one word. Words 0..5 of a point are R base, G base, B base, R delta, G delta, B delta, and after word 5 the point number increments. `data_wr` outside ST_LOAD has no effect.
- R5: `we_mask` bit 0 gates writes to red, bit 1 gates green and bit 2 gates blue. The value 7 writes all three. A channel whose bit is 0 keeps its old values.
- R6: The load completes, and the machine enters ST_READY, on the data write of word 5 of point `npoints-1`. While in ST_LOAD, outputs equal the inputs.
- R7: For an input x below 2^`start_exp`, the result is round(x*`lin_slope`/256), where `lin_slope` is unsigned with 8 fraction bits. This case takes priority over R9.
- R8: Otherwise let p be the bit position of the leading one of x, and let region k = p-`start_exp`. With s = min(region seglog, p) and f = p-s, the segment number is bits [p-1:f] of x and the fraction is bits [f-1:0] of x. The point used is (offset + segment) mod 128. The result is base + round(delta*fraction/2^f).
- R9: For x at or above `end_x`, the result is `end_base` + round((x-`end_x`)*`end_slope`/256), with `end_slope` having 8 fraction bits.
- R10: Every curve result above 4095 is saturated to 4095.
- R11: `rg_we` writes `rg_offset` and `rg_seglog` into region `rg_sel`. A rewrite takes effect for the following pixels without a reload of the point RAM.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| curve_en | input | 1 | 1 selects the programmed curve, 0 selects bypass |
| start_exp | input | 4 | Exponent of the first region start |
| lin_slope | input | 12 | Below-start slope, 4.8 unsigned |
| end_x | input | 12 | Input where extrapolation begins |
| end_base | input | 12 | Output value at `end_x` |
| end_slope | input | 12 | Above-end slope, 4.8 unsigned |
| rg_we | input | 1 | Region table write strobe |
| rg_sel | input | 4 | Region table entry to write |
| rg_offset | input | 7 | Point RAM base offset of the region |
| rg_seglog | input | 3 | log2 of the region's segment count |
| idx_wr | input | 1 | Load index write strobe; starts a load |
| idx_pt | input | 7 | Starting point number for the load |
| data_wr | input | 1 | Load data write strobe |
| data_in | input | 12 | Load data word |
| we_mask | input | 3 | Channel write mask (bit0 R, bit1 G, bit2 B) |
| npoints | input | 8 | Number of points; the load ends after point npoints-1 |
| pix_valid | input | 1 | Input pixel valid |
| pix_r | input | 12 | Red input component |
| pix_g | input | 12 | Green input component |
| pix_b | input | 12 | Blue input component |
| out_valid | output | 1 | Output pixel valid |
| out_r | output | 12 | Red result |
| out_g | output | 12 | Green result |
| out_b | output | 12 | Blue result |

## Verification
Every pixel result is due exactly one rising edge after the pixel is presented. The bench drives inputs on the falling edge, pushes the expected triple into a queue at that moment, and pops and compares on the next falling edge whenever `out_valid` is high. A state change caused by a load write also takes effect at the next edge. The bench therefore updates its own view of the load state only when it drives that write, so pixels sent in later cycles are judged against the right mode. Writes to the region table and point RAM take effect one edge after they are driven, and the bench leaves at least that cycle before sending pixels that depend on them.

// File: rtl/rgm_pkg.sv
`timescale 1ns/1ps
package rgm_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LOAD  = 2'd1,
        ST_READY = 2'd2
    } rgm_state_e;

    localparam int          SEGW      = 3;
    localparam logic [2:0]  SLOT_LAST = 3'd5;
    localparam int          NCH       = 3;
endpackage

// File: rtl/rgm_load_ctrl.sv
`timescale 1ns/1ps
module rgm_load_ctrl
    import rgm_pkg::*;
#(
    parameter int PAW = 7
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           idx_wr,
    input  logic [PAW-1:0] idx_pt,
    input  logic           data_wr,
    input  logic [PAW:0]   npoints,
    output rgm_state_e     state,
    output logic [PAW-1:0] wr_pt,
    output logic [2:0]     wr_slot,
    output logic           wr_fire
);
    rgm_state_e nxt;
    logic       last_word;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        last_word = (wr_slot == SLOT_LAST) && (({1'b0, wr_pt} + 1'b1) == npoints);
        wr_fire   = data_wr && !idx_wr && (state == ST_LOAD);
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:  if (idx_wr) nxt = ST_LOAD;
            ST_LOAD:  begin
                if (idx_wr)                    nxt = ST_LOAD;
                else if (wr_fire && last_word) nxt = ST_READY;
            end
            ST_READY: if (idx_wr) nxt = ST_LOAD;
            default:  nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_pt   <= '0;
            wr_slot <= '0;
        end else if (idx_wr) begin
            wr_pt   <= idx_pt;
            wr_slot <= '0;
        end else if (wr_fire) begin
            if (wr_slot == SLOT_LAST) begin
                wr_slot <= '0;
                wr_pt   <= wr_pt + 1'b1;
            end else begin
                wr_slot <= wr_slot + 1'b1;
            end
        end
    end
endmodule

// File: rtl/rgm_chan.sv
`timescale 1ns/1ps
module rgm_chan
    import rgm_pkg::*;
#(
    parameter int DW   = 12,
    parameter int NREG = 16,
    parameter int NPTS = 128,
    parameter int FRAC = 8,
    localparam int PAW = $clog2(NPTS),
    localparam int RAW = $clog2(NREG),
    localparam int EW  = $clog2(DW)
) (
    input  logic            clk,
    input  logic            wr_base,
    input  logic            wr_delta,
    input  logic [PAW-1:0]  wr_pt,
    input  logic [DW-1:0]   wr_data,
    input  logic [DW-1:0]   x,
    input  logic [EW-1:0]   start_exp,
    input  logic [DW-1:0]   lin_slope,
    input  logic [DW-1:0]   end_x,
    input  logic [DW-1:0]   end_base,
    input  logic [DW-1:0]   end_slope,
    input  logic [PAW-1:0]  reg_off [NREG],
    input  logic [SEGW-1:0] reg_seg [NREG],
    output logic [DW-1:0]   y
);
    localparam logic [31:0] RND  = 32'd1 << (FRAC - 1);
    localparam logic [31:0] YMAX = (32'd1 << DW) - 32'd1;

    logic [DW-1:0] base_mem  [NPTS];
    logic [DW-1:0] delta_mem [NPTS];

    always_ff @(posedge clk) begin
        if (wr_base)  base_mem[wr_pt]  <= wr_data;
        if (wr_delta) delta_mem[wr_pt] <= wr_data;
    end

    logic [31:0]    acc;
    logic [PAW-1:0] pt_sel;

    always_comb begin
        logic [31:0] xv, lead, rg, sl, fb, seg, fr, diff, half;
        xv   = 32'(x);
        lead = '0;
        for (int i = 0; i < DW; i++) begin
            if (x[i]) lead = 32'(i);
        end
        rg     = lead - 32'(start_exp);
        acc    = '0;
        pt_sel = '0;
        sl = '0; fb = '0; seg = '0; fr = '0; half = '0;
        diff = (xv >= 32'(end_x)) ? (xv - 32'(end_x)) : 32'd0;
        if ((32'(start_exp) >= 32'(DW)) || (xv < (32'd1 << start_exp))) begin
            acc = (xv * 32'(lin_slope) + RND) >> FRAC;
        end else if ((xv >= 32'(end_x)) || (rg >= 32'(NREG))) begin
            acc = 32'(end_base) + ((diff * 32'(end_slope) + RND) >> FRAC);
        end else begin
            sl     = (32'(reg_seg[rg[RAW-1:0]]) > lead) ? lead : 32'(reg_seg[rg[RAW-1:0]]);
            fb     = lead - sl;
            seg    = (xv >> fb) & ((32'd1 << sl) - 32'd1);
            fr     = xv & ((32'd1 << fb) - 32'd1);
            half   = (fb == 32'd0) ? 32'd0 : (32'd1 << (fb - 32'd1));
            pt_sel = reg_off[rg[RAW-1:0]] + seg[PAW-1:0];
            acc    = 32'(base_mem[pt_sel]) + ((32'(delta_mem[pt_sel]) * fr + half) >> fb);
        end
        y = (acc > YMAX) ? YMAX[DW-1:0] : acc[DW-1:0];
    end
endmodule

// File: rtl/rgm_regamma_top.sv
`timescale 1ns/1ps
module rgm_regamma_top
    import rgm_pkg::*;
#(
    parameter int DW   = 12,
    parameter int NREG = 16,
    parameter int NPTS = 128,
    parameter int FRAC = 8,
    localparam int PAW = $clog2(NPTS),
    localparam int RAW = $clog2(NREG),
    localparam int EW  = $clog2(DW)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            curve_en,
    input  logic [EW-1:0]   start_exp,
    input  logic [DW-1:0]   lin_slope,
    input  logic [DW-1:0]   end_x,
    input  logic [DW-1:0]   end_base,
    input  logic [DW-1:0]   end_slope,
    input  logic            rg_we,
    input  logic [RAW-1:0]  rg_sel,
    input  logic [PAW-1:0]  rg_offset,
    input  logic [SEGW-1:0] rg_seglog,
    input  logic            idx_wr,
    input  logic [PAW-1:0]  idx_pt,
    input  logic            data_wr,
    input  logic [DW-1:0]   data_in,
    input  logic [NCH-1:0]  we_mask,
    input  logic [PAW:0]    npoints,
    input  logic            pix_valid,
    input  logic [DW-1:0]   pix_r,
    input  logic [DW-1:0]   pix_g,
    input  logic [DW-1:0]   pix_b,
    output logic            out_valid,
    output logic [DW-1:0]   out_r,
    output logic [DW-1:0]   out_g,
    output logic [DW-1:0]   out_b
);
    rgm_state_e     state;
    logic [PAW-1:0] wr_pt;
    logic [2:0]     wr_slot;
    logic           wr_fire;
    logic           loading;
    logic           active;

    logic [PAW-1:0]  reg_off [NREG];
    logic [SEGW-1:0] reg_seg [NREG];
    logic [DW-1:0]   pix_a   [NCH];
    logic [DW-1:0]   y_a     [NCH];

    rgm_load_ctrl #(.PAW(PAW)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .idx_wr  (idx_wr),
        .idx_pt  (idx_pt),
        .data_wr (data_wr),
        .npoints (npoints),
        .state   (state),
        .wr_pt   (wr_pt),
        .wr_slot (wr_slot),
        .wr_fire (wr_fire)
    );

    always_comb begin
        loading  = (state == ST_LOAD);
        active   = (state == ST_READY) && curve_en;
        pix_a[0] = pix_r;
        pix_a[1] = pix_g;
        pix_a[2] = pix_b;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) begin
                reg_off[i] <= '0;
                reg_seg[i] <= '0;
            end
        end else if (rg_we) begin
            reg_off[rg_sel] <= rg_offset;
            reg_seg[rg_sel] <= rg_seglog;
        end
    end

    for (genvar c = 0; c < NCH; c++) begin : g_chan
        rgm_chan #(.DW(DW), .NREG(NREG), .NPTS(NPTS), .FRAC(FRAC)) u_chan (
            .clk       (clk),
            .wr_base   (wr_fire && we_mask[c] && (wr_slot == 3'(c))),
            .wr_delta  (wr_fire && we_mask[c] && (wr_slot == 3'(c + NCH))),
            .wr_pt     (wr_pt),
            .wr_data   (data_in),
            .x         (pix_a[c]),
            .start_exp (start_exp),
            .lin_slope (lin_slope),
            .end_x     (end_x),
            .end_base  (end_base),
            .end_slope (end_slope),
            .reg_off   (reg_off),
            .reg_seg   (reg_seg),
            .y         (y_a[c])
        );
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_r     <= '0;
            out_g     <= '0;
            out_b     <= '0;
        end else begin
            out_valid <= pix_valid;
            if (pix_valid) begin
                out_r <= active ? y_a[0] : pix_r;
                out_g <= active ? y_a[1] : pix_g;
                out_b <= active ? y_a[2] : pix_b;
            end
        end
    end
endmodule

// File: rtl/rgm_regamma_chk.sv
`timescale 1ns/1ps
module rgm_regamma_chk #(
    parameter int DW = 12
) (
    input logic          clk,
    input logic          rst_n,
    input logic          curve_en,
    input logic          idx_wr,
    input logic          loading,
    input logic          pix_valid,
    input logic [DW-1:0] pix_r,
    input logic [DW-1:0] pix_g,
    input logic          out_valid,
    input logic [DW-1:0] out_r,
    input logic [DW-1:0] out_g
);
    a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid |=> out_valid);

    a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !pix_valid |=> !out_valid);

    a_r3_bypass_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid && !curve_en) |=> (out_r == $past(pix_r)));

    a_r6_bypass_in_load: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid && loading) |=> (out_g == $past(pix_g)));

    a_r4_index_starts_load: assert property (@(posedge clk) disable iff (!rst_n)
        idx_wr |=> loading);
endmodule

bind rgm_regamma_top rgm_regamma_chk #(.DW(DW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .curve_en  (curve_en),
    .idx_wr    (idx_wr),
    .loading   (loading),
    .pix_valid (pix_valid),
    .pix_r     (pix_r),
    .pix_g     (pix_g),
    .out_valid (out_valid),
    .out_r     (out_r),
    .out_g     (out_g)
);

// File: tb/rgm_regamma_top_tb_top.sv
`timescale 1ns/1ps
module rgm_regamma_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        curve_en = 1'b0;
    logic [3:0]  start_exp = 4'd2;
    logic [11:0] lin_slope = 12'd512;
    logic [11:0] end_x = 12'd3072;
    logic [11:0] end_base = 12'd4000;
    logic [11:0] end_slope = 12'd128;
    logic        rg_we = 1'b0;
    logic [3:0]  rg_sel = '0;
    logic [6:0]  rg_offset = '0;
    logic [2:0]  rg_seglog = '0;
    logic        idx_wr = 1'b0;
    logic [6:0]  idx_pt = '0;
    logic        data_wr = 1'b0;
    logic [11:0] data_in = '0;
    logic [2:0]  we_mask = 3'd7;
    logic [7:0]  npoints = 8'd40;
    logic        pix_valid = 1'b0;
    logic [11:0] pix_r = '0, pix_g = '0, pix_b = '0;
    logic        out_valid;
    logic [11:0] out_r, out_g, out_b;

    always #10 clk = ~clk;

    rgm_regamma_top dut_i (
        .clk(clk), .rst_n(rst_n), .curve_en(curve_en), .start_exp(start_exp),
        .lin_slope(lin_slope), .end_x(end_x), .end_base(end_base), .end_slope(end_slope),
        .rg_we(rg_we), .rg_sel(rg_sel), .rg_offset(rg_offset), .rg_seglog(rg_seglog),
        .idx_wr(idx_wr), .idx_pt(idx_pt), .data_wr(data_wr), .data_in(data_in),
        .we_mask(we_mask), .npoints(npoints), .pix_valid(pix_valid),
        .pix_r(pix_r), .pix_g(pix_g), .pix_b(pix_b),
        .out_valid(out_valid), .out_r(out_r), .out_g(out_g), .out_b(out_b)
    );

    typedef struct {
        logic [11:0] r, g, b;
        string       tag;
    } exp_t;

    exp_t  sb_q[$];
    int    checks = 0;
    int    failures = 0;
    bit    bn_ready = 1'b0;
    bit    done = 1'b0;
    int    bn_off [16];
    int    bn_seg [16];
    int    bn_base [3][128];
    int    bn_delta [3][128];

    // Expected curve value from the requirement text (R7..R10).
    function automatic logic [11:0] expect_val(int ch, int x);
        int res, p, k, s, f, segn, fr, pt, half;
        if (x < (1 << start_exp)) begin
            res = (x * int'(lin_slope) + 128) / 256;                 // R7
        end else if (x >= int'(end_x)) begin
            res = int'(end_base) + ((x - int'(end_x)) * int'(end_slope) + 128) / 256; // R9
        end else begin
            p = 0;
            while ((x >> (p + 1)) != 0) p++;
            k    = p - int'(start_exp);                               // R8
            s    = (bn_seg[k] < p) ? bn_seg[k] : p;
            f    = p - s;
            segn = (x >> f) % (1 << s);
            fr   = x % (1 << f);
            pt   = (bn_off[k] + segn) % 128;
            half = (f == 0) ? 0 : (1 << (f - 1));
            res  = bn_base[ch][pt] + (bn_delta[ch][pt] * fr + half) / (1 << f);
        end
        if (res > 4095) res = 4095;                                   // R10
        return 12'(res);
    endfunction

    task automatic send_pix(input int r, input int g, input int b, input string tag);
        exp_t e;
        @(negedge clk);
        pix_valid = 1'b1;
        pix_r = 12'(r); pix_g = 12'(g); pix_b = 12'(b);
        if (bn_ready && curve_en) begin
            e.r = expect_val(0, r); e.g = expect_val(1, g); e.b = expect_val(2, b);
        end else begin
            e.r = 12'(r); e.g = 12'(g); e.b = 12'(b);
        end
        e.tag = tag;
        sb_q.push_back(e);
        @(negedge clk);
        pix_valid = 1'b0;
    endtask

    task automatic set_region(input int k, input int off, input int sg);
        @(negedge clk);
        rg_we = 1'b1; rg_sel = 4'(k); rg_offset = 7'(off); rg_seglog = 3'(sg);
        bn_off[k] = off; bn_seg[k] = sg;
        @(negedge clk);
        rg_we = 1'b0;
    endtask

    task automatic start_load(input int pt);
        @(negedge clk);
        idx_wr = 1'b1; idx_pt = 7'(pt);
        bn_ready = 1'b0;
        @(negedge clk);
        idx_wr = 1'b0;
    endtask

    // Six words per point in the order R, G, B bases then R, G, B deltas (R4).
    task automatic load_point(input int pt, input int w [6], input bit last);
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            data_wr = 1'b1; data_in = 12'(w[i]);
            if (we_mask[i % 3]) begin
                if (i < 3) bn_base[i][pt] = w[i];
                else       bn_delta[i - 3][pt] = w[i];
            end
            if (last && i == 5) bn_ready = 1'b1;
        end
        @(negedge clk);
        data_wr = 1'b0;
    endtask

    function automatic void chk(input bit ok, input string tag, input int act, input int exp_v);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp_v);
        end
    endfunction

    // Monitor: pops one expected triple per valid output.
    always @(negedge clk) begin
        if (rst_n && out_valid && !done) begin
            if (sb_q.size() == 0) begin
                chk(1'b0, "R2 unexpected out_valid", 1, 0);
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                chk(out_r == e.r, {e.tag, " red"},   int'(out_r), int'(e.r));
                chk(out_g == e.g, {e.tag, " green"}, int'(out_g), int'(e.g));
                chk(out_b == e.b, {e.tag, " blue"},  int'(out_b), int'(e.b));
            end
        end
    end

    initial begin
        #(20 * 200000);
        failures++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int w [6];
        int xs [14];
        repeat (3) @(negedge clk);
        chk(out_valid == 1'b0, "R1 reset out_valid", int'(out_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(out_valid == 1'b0 && out_r == 0 && out_g == 0 && out_b == 0,
            "R1 outputs after reset", int'(out_r), 0);

        // R3: curve requested but nothing loaded yet
        curve_en = 1'b1;
        send_pix(1000, 2000, 3000, "R3 no curve loaded");

        for (int k = 0; k < 16; k++) set_region(k, 4 * k, 2);      // R11 table fill

        start_load(0);
        for (int p = 0; p < 40; p++) begin
            w[0] = p * 100; w[1] = p * 90 + 7; w[2] = p * 100;
            w[3] = 100;     w[4] = 90;         w[5] = 4000;
            load_point(p, w, p == 39);
            if (p == 20) send_pix(500, 600, 700, "R6 bypass during load");
        end

        xs = '{0, 1, 3, 4, 7, 100, 1000, 1500, 2047, 2500, 3000, 3071, 3072, 4095};
        for (int i = 0; i < 14; i++)
            send_pix(xs[i], xs[13 - i], xs[(i + 5) % 14], "R8 R7 R9 R10 curve lookup");

        curve_en = 1'b0;
        send_pix(2500, 100, 3, "R3 curve disabled");
        curve_en = 1'b1;

        // R4: data writes while ready are ignored
        for (int i = 0; i < 6; i++) begin
            @(negedge clk); data_wr = 1'b1; data_in = 12'hABC;
        end
        @(negedge clk); data_wr = 1'b0;
        send_pix(1000, 2500, 300, "R4 stray data ignored");

        // R5: green-only reload
        we_mask = 3'b010;
        start_load(0);
        for (int p = 0; p < 40; p++) begin
            w[0] = 4095; w[1] = p * 50; w[2] = 0;
            w[3] = 0;    w[4] = 50;     w[5] = 0;
            load_point(p, w, p == 39);
        end
        we_mask = 3'b111;
        send_pix(1500, 1500, 1500, "R5 mask green only");
        send_pix(40, 2900, 2900, "R5 mask green only");

        // R11: region rewrite, single segment
        set_region(9, 36, 0);
        send_pix(2600, 2700, 2800, "R11 region rewrite");

        // R6: short load, completion on point npoints-1
        npoints = 8'd6;
        start_load(5);
        send_pix(9, 9, 9, "R6 bypass after restart");
        w = '{111, 222, 333, 5, 6, 7};
        load_point(5, w, 1'b1);
        send_pix(8, 9, 11, "R6 complete short load");
        send_pix(1023, 1024, 2047, "R6 complete short load");

        repeat (4) @(negedge clk);
        chk(sb_q.size() == 0, "R2 all results delivered", sb_q.size(), 0);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule